// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in and returns their sum and a carry-out. The operand width is cut into four 4-bit groups. Inside each group, every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each carry within the group is then written as one flat sum of products of those terms and the group's incoming carry, so no carry ripples from bit to bit.

Each group also reports a group generate and a group propagate. A second lookahead stage combines the four group pairs with the external carry-in. It produces the carry into every group and the final carry-out in the same flat form, so no group waits on a carry rippled through its neighbour.

The adder is meant to sit inside an execution datapath, where it is used for addition only. Subtraction and condition flags belong to the logic around it.

Top module: `cla_adder16`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) modulo 2^16 for every input combination.
- R2: `carryOut` is 1 exactly when `opA` + `opB` + `carryIn` is at least 2^16.
- R3: For fixed operands, raising `carryIn` from 0 to 1 increases the 17-bit result {`carryOut`,`sumOut`} by exactly one.
- R4: When every bit position has exactly one operand bit set, the carry-in travels through all 16 bits: with `carryIn`=1 the sum is 0x0000 and the carry-out is 1, and with `carryIn`=0 the sum is 0xFFFF and the carry-out is 0.
- R5: A carry created in the lowest group reaches the carry-out when all higher bits propagate: 0xFFFF + 0x0001 with `carryIn`=0 gives sum 0x0000 and carry-out 1.
- R6: Bit positions where both operand bits are 1 count as both generating and propagating, and the result stays correct: 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF and carry-out 1.
- R7: With both operands zero, the sum equals `carryIn` and the carry-out is 0.
- R8: The carry into group k+1 equals G_k OR (P_k AND carry into group k), where the carry into group 0 is `carryIn` and the carry out of group 3 is `carryOut`. At the port, a carry generated at the top bit of any group is added to the lowest bit of the next group, for example 0x000F + 0x0001 = 0x0010.
- R9: A group's propagate is the AND of (a_i OR b_i) over its four bits. A group's generate is the carry out of that group's 4-bit slice when its carry-in is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum modulo 2^16 |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
The checks bound to the adder assume that the operands and the carry-in are two-state and stable when they are sampled. Under that assumption the group terms, the group carries and the sum can be compared directly with arithmetic done on the same inputs. The bench sets every input on the falling clock edge and reads the outputs a little later, after the combinational paths have settled. Random operands come from a fixed seed. Directed cases target full-length propagation, values where both operand bits are 1, and a carry crossing each group boundary.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_GRP_W   = 4;
  localparam int DEF_NUM_GRP = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } grpTerm_t;
endpackage

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W
) (
  input  logic [GRP_W-1:0] a,
  input  logic [GRP_W-1:0] b,
  input  logic             cin,
  output logic [GRP_W-1:0] sum,
  output grpTerm_t         term
);
  logic [GRP_W-1:0] bitGen;
  logic [GRP_W-1:0] bitProp;
  logic [GRP_W-1:0] bitCarry;

  assign bitGen  = a & b;
  assign bitProp = a | b;

  // each carry is a flat sum of products over bit generate/propagate and cin
  always_comb begin
    logic acc;
    logic run;
    bitCarry[0] = cin;
    for (int k = 1; k < GRP_W; k++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (bitGen[j] & run);
        run = run & bitProp[j];
      end
      bitCarry[k] = acc | (run & cin);
    end
  end

  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int j = GRP_W - 1; j >= 0; j--) begin
      acc = acc | (bitGen[j] & run);
      run = run & bitProp[j];
    end
    term.gen  = acc;
    term.prop = run;
  end

  assign sum = a ^ b ^ bitCarry;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int NUM_GRP = DEF_NUM_GRP
) (
  input  grpTerm_t [NUM_GRP-1:0] terms,
  input  logic                   cin,
  output logic     [NUM_GRP:0]   groupCarry
);
  // carry into every group, expanded flat across group terms
  always_comb begin
    logic acc;
    logic run;
    groupCarry[0] = cin;
    for (int k = 1; k <= NUM_GRP; k++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (terms[j].gen & run);
        run = run & terms[j].prop;
      end
      groupCarry[k] = acc | (run & cin);
    end
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int GRP_W   = DEF_GRP_W,
  parameter int NUM_GRP = DEF_NUM_GRP,
  localparam int DATA_W = GRP_W * NUM_GRP
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);
  grpTerm_t [NUM_GRP-1:0] grpTerms;
  logic     [NUM_GRP:0]   groupCarry;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    cla_group #(.GRP_W(GRP_W)) u_grp (
      .a   (opA[g*GRP_W +: GRP_W]),
      .b   (opB[g*GRP_W +: GRP_W]),
      .cin (groupCarry[g]),
      .sum (sumOut[g*GRP_W +: GRP_W]),
      .term(grpTerms[g])
    );
  end

  cla_lookahead #(.NUM_GRP(NUM_GRP)) u_look (
    .terms     (grpTerms),
    .cin       (carryIn),
    .groupCarry(groupCarry)
  );

  assign carryOut = groupCarry[NUM_GRP];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk
  import cla_pkg::*;
#(
  parameter int GRP_W   = DEF_GRP_W,
  parameter int NUM_GRP = DEF_NUM_GRP,
  localparam int DATA_W = GRP_W * NUM_GRP
) (
  input logic     [DATA_W-1:0]  opA,
  input logic     [DATA_W-1:0]  opB,
  input logic                   carryIn,
  input logic     [DATA_W-1:0]  sumOut,
  input logic                   carryOut,
  input grpTerm_t [NUM_GRP-1:0] grpTerms,
  input logic     [NUM_GRP:0]   groupCarry
);
  logic [DATA_W:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    a_r1_sum_value: assert (sumOut == refTotal[DATA_W-1:0])
      else $error("R1 sum mismatch");
    a_r2_carry_out: assert (carryOut == refTotal[DATA_W])
      else $error("R2 carry-out mismatch");
    if (((opA ^ opB) == {DATA_W{1'b1}}) && carryIn)
      a_r4_full_propagate: assert (sumOut == '0 && carryOut)
        else $error("R4 full-length propagate failed");
    a_r8_entry_carry: assert (groupCarry[0] == carryIn)
      else $error("R8 group 0 carry differs from carry-in");
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_chk
    logic [GRP_W:0] sliceSum;
    assign sliceSum = {1'b0, opA[g*GRP_W +: GRP_W]} + {1'b0, opB[g*GRP_W +: GRP_W]};
    always_comb begin
      a_r8_group_carry: assert (groupCarry[g+1] ==
          (grpTerms[g].gen | (grpTerms[g].prop & groupCarry[g])))
        else $error("R8 group carry %0d inconsistent", g + 1);
      a_r9_group_prop: assert (grpTerms[g].prop ==
          &(opA[g*GRP_W +: GRP_W] | opB[g*GRP_W +: GRP_W]))
        else $error("R9 group propagate %0d wrong", g);
      a_r9_group_gen: assert (grpTerms[g].gen == sliceSum[GRP_W])
        else $error("R9 group generate %0d wrong", g);
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .sumOut    (sumOut),
  .carryOut  (carryOut),
  .grpTerms  (grpTerms),
  .groupCarry(groupCarry)
);

// File: tb/cla_adder16_bench.sv
`timescale 1ns/1ps
module cla_adder16_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cla_adder16 u_cla_adder16 (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic logic [16:0] refAdd(input logic [15:0] x, input logic [15:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(negedge clk);
    opA = x; opB = y; carryIn = c;
    #2;
  endtask

  task automatic expect17(input string tag, input logic [16:0] exp);
    nChecks++;
    if ({carryOut, sumOut} !== exp) begin
      nFails++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h",
               tag, opA, opB, carryIn, {carryOut, sumOut}, exp);
    end
  endtask

  task automatic checkRef(input string tag, input logic [15:0] x, input logic [15:0] y,
                          input logic c);
    drive(x, y, c);
    expect17(tag, refAdd(x, y, c));
  endtask

  initial begin
    logic [16:0] lowRes;
    logic [15:0] ra, rb;
    void'($urandom(32'd1234));
    // reset state: zero inputs held during reset (R7)
    #2;
    expect17("R7 reset", 17'h00000);
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    drive(16'h0000, 16'h0000, 1'b1); expect17("R7 zero cin1", 17'h00001);
    drive(16'h0000, 16'h0000, 1'b0); expect17("R7 zero cin0", 17'h00000);
    drive(16'hFFFF, 16'h0000, 1'b1); expect17("R4 prop cin1", 17'h10000);
    drive(16'h5555, 16'hAAAA, 1'b1); expect17("R4 alt cin1", 17'h10000);
    drive(16'h5555, 16'hAAAA, 1'b0); expect17("R4 alt cin0", 17'h0FFFF);
    drive(16'hFFFF, 16'h0001, 1'b0); expect17("R5 low gen", 17'h10000);
    drive(16'hFFFF, 16'hFFFF, 1'b1); expect17("R6 both ones", 17'h1FFFF);
    drive(16'hFFFF, 16'hFFFF, 1'b0); expect17("R6 both ones cin0", 17'h1FFFE);
    drive(16'h000F, 16'h0001, 1'b0); expect17("R8 boundary 0", 17'h00010);
    drive(16'h00F0, 16'h0010, 1'b0); expect17("R8 boundary 1", 17'h00100);
    drive(16'h0F00, 16'h0100, 1'b0); expect17("R8 boundary 2", 17'h01000);
    drive(16'hF000, 16'h1000, 1'b0); expect17("R8 boundary 3", 17'h10000);
    drive(16'h0888, 16'h0888, 1'b0); expect17("R9 group gen", 17'h01110);
    drive(16'h0F0F, 16'h0000, 1'b1); expect17("R9 group prop", 17'h00F10);

    for (int i = 0; i < 3000; i++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (i % 50 == 0) rb = ~ra;
      drive(ra, rb, 1'b0);
      lowRes = {carryOut, sumOut};
      expect17("R1 R2 random cin0", refAdd(ra, rb, 1'b0));
      drive(ra, rb, 1'b1);
      expect17("R3 cin step", lowRes + 17'd1);
      checkRef("R1 R2 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule